// File: doc/BRIEF.md
# Store-Multiple Transfer Sequencer

This block breaks one store-multiple instruction into a series of single-word write requests. A command carries a 16-bit register list, a 32-bit base address, the two addressing bits P and U, the current processor mode and the index of the base register. The sequencer works out the first write address and then walks the list from the lowest selected register to the highest. For each selected register it drives a read index towards a user-bank register-file read port. It then offers the address, the register index and the data on a valid/ready write port.

Back-pressure on the write port works as follows. Once `wr_valid` is high, address, index and data stay unchanged until a cycle with `wr_ready` high. The next request, if there is one, is offered in the very next cycle. A command is taken in any cycle where `cmd_valid` is high and `busy` is low. Command pins are plain control and are sampled only in that cycle.

Illegal cases are rejected when the command is taken, and no write is issued for them. Hypervisor mode raises an undefined-instruction pulse. User mode, system mode, an empty list or a base index of 15 raise an unpredictable pulse. A start address that is not word-aligned raises an alignment-fault pulse. The block never changes the base register.

Top module: `stm_seq`

## Requirements
- R1: The first write address is `cmd_base` when U=1, or `cmd_base` minus 4×(number of set list bits) when U=0. In both cases 4 is added when P equals U. So {P,U}=00 is decrement-after, 10 is decrement-before, 01 is increment-after and 11 is increment-before.
- R2: Selected registers are written in ascending index order, and each address is 4 more than the previous one. With `wr_ready` held high, successive writes come in back-to-back cycles, and the first one comes in the cycle after the command is taken.
- R3: For an index 0..14, `rf_idx` equals `wr_reg` and `wr_data` equals `rf_data`, where `rf_data` is the combinational user-bank read of `rf_idx`. For index 15, `wr_data` is the `pc_store` value captured when the command was taken.
- R4: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_reg` and `wr_data` hold their values into the next cycle.
- R5: `busy` is high from the cycle after a legal command is taken until the final write is accepted. `done` pulses for exactly one cycle, in the cycle after the final accepted write.
- R6: Mode codes are 3 bits: 0 user, 1 system, 2 hypervisor, 3..7 other privileged modes. A command in hypervisor mode pulses `undef_flag` for one cycle in the cycle after it is taken, and issues no write.
- R7: A command in user or system mode, or with an empty list, or with `cmd_rn`=15, pulses `unpred_flag` one cycle after it is taken and issues no write.
- R8: A command whose start address has nonzero bits [1:0] pulses `align_flag` one cycle after it is taken and issues no write. Every issued `wr_addr` has bits [1:0] equal to 0.
- R9: A `cmd_valid` pulse while `busy` is high has no effect on the running sequence.
- R10: Only one flag is raised per command, with priority undefined, then unpredictable, then alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken while busy is low |
| cmd_list | input | 16 | Register selection list |
| cmd_base | input | 32 | Base register value |
| cmd_p | input | 1 | P addressing bit |
| cmd_u | input | 1 | U addressing bit |
| cmd_mode | input | 3 | Current processor mode code |
| cmd_rn | input | 4 | Base register index |
| pc_store | input | 32 | Value stored for index 15 |
| busy | output | 1 | Sequence in progress |
| rf_idx | output | 4 | User-bank read index |
| rf_data | input | 32 | User-bank read data for rf_idx |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 32 | Word write address |
| wr_reg | output | 4 | Register index of the word |
| wr_data | output | 32 | Word to store |
| done | output | 1 | One-cycle pulse after the final write |
| undef_flag | output | 1 | Hypervisor-mode rejection pulse |
| unpred_flag | output | 1 | Unpredictable-case rejection pulse |
| align_flag | output | 1 | Misaligned start rejection pulse |

## Verification
If the remaining-list register is wrong, writes are skipped or repeated, and this shows on `wr_reg` within one accepted write. It also moves `done` early or late. A wrong address register shows on `wr_addr` at the first write or one write after the fault. If the state or flag logic is wrong, a rejected command issues writes or a legal one raises a flag, and this is visible one cycle after the command is taken. A hold fault shows in the first stalled cycle as a changed request.

// File: rtl/stm_pkg.sv
package stm_pkg;
  typedef enum logic [2:0] {
    MODE_USR = 3'd0,
    MODE_SYS = 3'd1,
    MODE_HYP = 3'd2
  } mode_e;

  typedef enum logic [1:0] {
    CLS_OK     = 2'd0,
    CLS_UNDEF  = 2'd1,
    CLS_UNPRED = 2'd2,
    CLS_ALIGN  = 2'd3
  } cls_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } state_e;
endpackage

// File: rtl/stm_start_addr.sv
module stm_start_addr #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0] list,
  input  logic [AW-1:0]   base,
  input  logic            p,
  input  logic            u,
  output logic [CW-1:0]   count,
  output logic [AW-1:0]   start
);
  logic [AW-1:0] span;
  logic [AW-1:0] first;

  always_comb begin
    count = '0;
    for (int i = 0; i < NREG; i++) count = count + CW'(list[i]);
  end

  assign span  = AW'(count) << 2;
  assign first = u ? base : (base - span);
  assign start = (p == u) ? first + AW'(4) : first;
endmodule

// File: rtl/stm_bit_pick.sv
module stm_bit_pick #(
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic [NREG-1:0] vec,
  output logic [IW-1:0]   idx,
  output logic            last
);
  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) if (vec[i]) idx = IW'(i);
  end

  assign last = ($countones(vec) == 1);
endmodule

// File: rtl/stm_cmd_check.sv
module stm_cmd_check
  import stm_pkg::*;
#(
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic [2:0]      mode,
  input  logic [NREG-1:0] list,
  input  logic [IW-1:0]   rn,
  input  logic [1:0]      start_lo,
  output cls_e            cls
);
  always_comb begin
    if (mode == MODE_HYP)
      cls = CLS_UNDEF;
    else if (mode == MODE_USR || mode == MODE_SYS || list == '0 || rn == IW'(NREG - 1))
      cls = CLS_UNPRED;
    else if (start_lo != 2'b00)
      cls = CLS_ALIGN;
    else
      cls = CLS_OK;
  end
endmodule

// File: rtl/stm_seq.sv
module stm_seq
  import stm_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG),
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [NREG-1:0] cmd_list,
  input  logic [AW-1:0]   cmd_base,
  input  logic            cmd_p,
  input  logic            cmd_u,
  input  logic [2:0]      cmd_mode,
  input  logic [IW-1:0]   cmd_rn,
  input  logic [DW-1:0]   pc_store,
  output logic            busy,
  output logic [IW-1:0]   rf_idx,
  input  logic [DW-1:0]   rf_data,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [AW-1:0]   wr_addr,
  output logic [IW-1:0]   wr_reg,
  output logic [DW-1:0]   wr_data,
  output logic            done,
  output logic            undef_flag,
  output logic            unpred_flag,
  output logic            align_flag
);
  state_e          state;
  logic [NREG-1:0] remain;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   pc_q;
  logic [CW-1:0]   count;
  logic [AW-1:0]   start;
  logic [IW-1:0]   cur;
  logic            last;
  cls_e            cls;
  logic            take;
  logic            fire;

  stm_start_addr #(.NREG(NREG), .AW(AW)) u_addr (
    .list(cmd_list), .base(cmd_base), .p(cmd_p), .u(cmd_u),
    .count(count), .start(start)
  );

  stm_cmd_check #(.NREG(NREG)) u_check (
    .mode(cmd_mode), .list(cmd_list), .rn(cmd_rn),
    .start_lo(start[1:0]), .cls(cls)
  );

  stm_bit_pick #(.NREG(NREG)) u_pick (
    .vec(remain), .idx(cur), .last(last)
  );

  assign take = cmd_valid && (state == ST_IDLE);
  assign fire = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      remain      <= '0;
      addr_q      <= '0;
      pc_q        <= '0;
      done        <= 1'b0;
      undef_flag  <= 1'b0;
      unpred_flag <= 1'b0;
      align_flag  <= 1'b0;
    end else begin
      done        <= 1'b0;
      undef_flag  <= 1'b0;
      unpred_flag <= 1'b0;
      align_flag  <= 1'b0;
      if (take) begin
        undef_flag  <= (cls == CLS_UNDEF);
        unpred_flag <= (cls == CLS_UNPRED);
        align_flag  <= (cls == CLS_ALIGN);
        if (cls == CLS_OK) begin
          state  <= ST_RUN;
          remain <= cmd_list;
          addr_q <= start;
          pc_q   <= pc_store;
        end
      end else if (fire) begin
        remain[cur] <= 1'b0;
        addr_q      <= addr_q + AW'(4);
        if (last) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      end
    end
  end

  assign busy     = (state == ST_RUN);
  assign wr_valid = busy;
  assign wr_addr  = addr_q;
  assign wr_reg   = cur;
  assign rf_idx   = cur;
  assign wr_data  = (cur == IW'(NREG - 1)) ? pc_q : rf_data;

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last) |=> (wr_valid && wr_reg > $past(wr_reg) && wr_addr == $past(wr_addr) + AW'(4)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_reg)));

  assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(fire) && !busy));

  assert_undef_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    undef_flag |-> (!wr_valid && !done));

  assert_unpred_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unpred_flag |-> (!wr_valid && !done));

  assert_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[1:0] == 2'b00));

  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fire) |=> (busy && $stable(wr_addr)));

  assert_one_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({undef_flag, unpred_flag, align_flag}));
endmodule

// File: tb/stm_seq_test.sv
module stm_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  localparam logic [31:0] PCV = 32'hCAFE_0008;

  // list, base, p, u, mode, rn
  localparam logic [56:0] VEC [NV] = '{
    {16'h000F, 32'h0000_1000, 1'b0, 1'b1, 3'd3, 4'd1},
    {16'h8001, 32'h0000_2000, 1'b1, 1'b1, 3'd4, 4'd2},
    {16'h00F0, 32'h0000_3000, 1'b0, 1'b0, 3'd3, 4'd3},
    {16'h4201, 32'h0000_4000, 1'b1, 1'b0, 3'd6, 4'd4},
    {16'hFFFF, 32'h0000_0100, 1'b0, 1'b1, 3'd5, 4'd0},
    {16'h0001, 32'h0000_0000, 1'b1, 1'b0, 3'd3, 4'd13},
    {16'h0003, 32'h0000_5000, 1'b0, 1'b1, 3'd2, 4'd1},
    {16'h0003, 32'h0000_5000, 1'b0, 1'b1, 3'd1, 4'd1},
    {16'h0003, 32'h0000_5000, 1'b0, 1'b1, 3'd3, 4'd15},
    {16'h0000, 32'h0000_5000, 1'b0, 1'b1, 3'd3, 4'd1},
    {16'h0003, 32'h0000_5002, 1'b0, 1'b1, 3'd3, 4'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [15:0] cmd_list = '0;
  logic [31:0] cmd_base = '0;
  logic cmd_p = 1'b0, cmd_u = 1'b0;
  logic [2:0] cmd_mode = '0;
  logic [3:0] cmd_rn = '0;
  logic [31:0] pc_store = PCV;
  logic busy, wr_valid, done, undef_flag, unpred_flag, align_flag;
  logic [3:0] rf_idx, wr_reg;
  logic [31:0] rf_data, wr_addr, wr_data;
  logic wr_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign rf_data = 32'hD000_0000 + {28'd0, rf_idx} * 32'h0101;

  stm_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_list(cmd_list),
    .cmd_base(cmd_base), .cmd_p(cmd_p), .cmd_u(cmd_u), .cmd_mode(cmd_mode),
    .cmd_rn(cmd_rn), .pc_store(pc_store), .busy(busy), .rf_idx(rf_idx),
    .rf_data(rf_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_reg(wr_reg), .wr_data(wr_data), .done(done),
    .undef_flag(undef_flag), .unpred_flag(unpred_flag), .align_flag(align_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic issue(input logic [56:0] v);
    @(negedge clk);
    {cmd_list, cmd_base, cmd_p, cmd_u, cmd_mode, cmd_rn} = v;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Drives one command and checks every resulting write; stall selects an alternating ready.
  task automatic run_vec(input logic [56:0] v, input bit stall, input bit busy_poke);
    logic [15:0] lst;
    logic [31:0] base, a;
    logic p, u;
    logic [2:0] md;
    logic [3:0] rn;
    int n, cls, seen, waited;
    {lst, base, p, u, md, rn} = v;
    n = $countones(lst);
    a = u ? base : base - 32'(4 * n);
    if (p == u) a = a + 32'd4;
    if (md == 3'd2) cls = 1;
    else if (md == 3'd0 || md == 3'd1 || lst == 16'h0 || rn == 4'd15) cls = 2;
    else if (a[1:0] != 2'b00) cls = 3;
    else cls = 0;
    wr_ready = !stall;
    issue(v);
    chk(undef_flag == (cls == 1), "R6 undef_flag", {31'd0, undef_flag}, {31'd0, cls == 1});
    chk(unpred_flag == (cls == 2), "R7/R10 unpred_flag", {31'd0, unpred_flag}, {31'd0, cls == 2});
    chk(align_flag == (cls == 3), "R8/R10 align_flag", {31'd0, align_flag}, {31'd0, cls == 3});
    if (cls != 0) begin
      chk(!wr_valid && !busy, "R6/R7/R8 no write", {31'd0, wr_valid}, 32'd0);
      @(negedge clk);
      chk(!wr_valid && !done, "R6/R7/R8 still idle", {31'd0, wr_valid}, 32'd0);
      return;
    end
    chk(busy, "R5 busy after take", {31'd0, busy}, 32'd1);
    seen = 0;
    waited = 0;
    for (int r = 0; r < 16; r++) begin
      if (lst[r]) begin
        while (1) begin
          if (stall) wr_ready = (waited % 2 == 1);
          if (busy_poke && waited == 0) begin
            cmd_valid = 1'b1;
            cmd_list = 16'h0002;
            cmd_base = 32'h0000_9000;
          end
          chk(wr_valid, "R2 wr_valid", {31'd0, wr_valid}, 32'd1);
          chk(wr_reg == 4'(r), "R2 order", {28'd0, wr_reg}, r);
          chk(wr_addr == a, "R1/R2 address", wr_addr, a);
          chk(wr_data == ((r == 15) ? PCV : 32'hD000_0000 + 32'(r) * 32'h0101),
              "R3 data", wr_data, (r == 15) ? PCV : 32'hD000_0000 + 32'(r) * 32'h0101);
          waited++;
          if (wr_ready) break;
          @(negedge clk);
          cmd_valid = 1'b0;
          chk(wr_addr == a && wr_reg == 4'(r), "R4/R9 hold", wr_addr, a);
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        a = a + 32'd4;
        seen++;
        waited = 0;
      end
    end
    chk(done && !busy, "R5 done pulse", {31'd0, done}, 32'd1);
    chk(!wr_valid, "R5 no extra write", {31'd0, wr_valid}, 32'd0);
    wr_ready = 1'b0;
    @(negedge clk);
    chk(!done, "R5 done one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !wr_valid && !done && !undef_flag && !unpred_flag && !align_flag,
        "reset state", {26'd0, busy, wr_valid, done, undef_flag, unpred_flag, align_flag}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run_vec(VEC[i], (i % 2) == 1, 1'b0);
    // R2: back-to-back writes with ready held high, counted in cycles
    begin
      int t0;
      wr_ready = 1'b1;
      issue({16'h0505, 32'h0000_6000, 1'b0, 1'b1, 3'd3, 4'd1});
      t0 = cycles;
      while (!done) @(negedge clk);
      chk(cycles - t0 == 4, "R2 no gap", cycles - t0, 32'd4);
      wr_ready = 1'b0;
    end
    // R9: command strobe while busy is ignored
    run_vec({16'h0090, 32'h0000_7000, 1'b1, 1'b1, 3'd3, 4'd1}, 1'b1, 1'b1);
    // R10: hypervisor wins over empty list; unpredictable wins over misalignment
    run_vec({16'h0000, 32'h0000_7001, 1'b0, 1'b1, 3'd2, 4'd15}, 1'b0, 1'b0);
    run_vec({16'h0001, 32'h0000_7001, 1'b0, 1'b1, 3'd0, 4'd1}, 1'b0, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule